// File: doc/BRIEF.md
# Disk Command Block Issuer

This block turns one read or write request into a four-word command block and hands it to a disk attachment one word at a time. A request carries a linear block address, a byte count, a device number and a read/write flag. The block converts the linear address into cylinder, head and sector using the configured sectors-per-track and head counts. The conversion runs on a shared iterative divider, first for the track and sector and then for the cylinder and head.

Before the first word goes out, the block asks a separate attention sequencer for a command-request attention and waits for it to be granted. Each word is written with a one-cycle strobe. The block then polls the attachment's full flag until the word has been taken. The poll is bounded, and a device that holds the flag too long ends the command as slow. After the last word, the block waits a bounded time for a done or error completion from the interrupt side. It reports one result code with a single-cycle valid pulse.

Top module: `disk_cmd_issuer`

## Requirements
- R1: During and right after reset, busy, attn_req, cmd_wr and result_valid are low and result_code is 0.
- R2: sector = lba mod spt, head = (lba div spt) mod heads, and cylinder = low 10 bits of ((lba div spt) div heads). Both configuration values must be nonzero.
- R3: Word 0 has bits 15:14 = 01 (four-word block), bits 13:8 = 000010 (options), bits 7:5 = device number and bits 4:0 = command code (1 = read, 2 = write).
- R4: Word 1 is the block count, byte_count shifted right by BLK_SHIFT (512-byte blocks by default, remainder dropped).
- R5: Word 2 holds cylinder bits 4:0 in bits 15:11, the head in bits 10:5 and the sector in bits 4:0. Word 3 holds cylinder bits 9:5 in bits 4:0 with bits 15:5 zero.
- R6: attn_req stays high until attn_done. No word is written before attn_done arrives with attn_ok = 1. If attn_ok = 0, the command ends with code 4 and no words are written.
- R7: Words go out in order 0, 1, 2, 3. Each word gets a one-cycle cmd_wr. A word is never written while cmd_full is high, and the next word waits until cmd_full has been seen low.
- R8: If cmd_full is still high on the POLL_MAX-th poll cycle after a write, the command ends with code 2 and no later word is written. If the flag clears on that last poll cycle, the word counts as accepted.
- R9: A completion (cmp_valid) with cmp_done = 1 gives code 0. With cmp_done = 0 it gives code 1.
- R10: If no completion arrives within CMP_TIMEOUT wait cycles, the command ends with code 3. A completion on the last wait cycle still counts as a completion.
- R11: result_valid is a one-cycle pulse. busy is low in the following cycle.
- R12: A start that arrives while busy is ignored. The running command's words and result are unchanged, and no second command follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| is_write | input | 1 | 1 = write command, 0 = read command |
| dev_sel | input | 3 | Device number placed in word 0 |
| lba | input | LBA_W | Linear block address |
| byte_count | input | BC_W | Transfer length in bytes |
| cfg_spt | input | 6 | Sectors per track (1 to 32) |
| cfg_heads | input | 7 | Heads per cylinder (1 to 64) |
| attn_req | output | 1 | Command-request attention wanted |
| attn_done | input | 1 | Attention sequencer finished |
| attn_ok | input | 1 | Attention outcome, valid with attn_done |
| cmd_wr | output | 1 | Write strobe for cmd_word |
| cmd_word | output | 16 | Command word to the attachment |
| cmd_full | input | 1 | Attachment has not yet taken the last word |
| cmp_valid | input | 1 | Completion indication from the interrupt side |
| cmp_done | input | 1 | 1 = done status, 0 = error, valid with cmp_valid |
| busy | output | 1 | A command is in progress |
| result_valid | output | 1 | One-cycle result strobe |
| result_code | output | 3 | 0 ok, 1 I/O error, 2 slow device, 3 timeout, 4 attention failed |

## Verification
Two decisions can fall in the same cycle. The attachment can clear cmd_full in exactly the cycle the poll limit runs out, and a completion can arrive in exactly the cycle the wait limit runs out. The bench models the attachment and the interrupt side with cycle-exact delays. It sets the full-hold time to POLL_MAX-1 and POLL_MAX, and the completion delay to CMP_TIMEOUT-1 and CMP_TIMEOUT. It expects success at the first value of each pair and the slow or timeout code at the second.

// File: rtl/disk_cmd_pkg.sv
package disk_cmd_pkg;

   typedef enum logic [2:0] {
      RES_OK        = 3'd0,
      RES_IO_ERR    = 3'd1,
      RES_SLOW      = 3'd2,
      RES_TIMEOUT   = 3'd3,
      RES_ATTN_FAIL = 3'd4
   } res_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_GO_TRK,
      ST_RUN_TRK,
      ST_GO_CYL,
      ST_RUN_CYL,
      ST_ATTN,
      ST_SEND,
      ST_POLL,
      ST_WAIT,
      ST_DONE
   } st_e;

   localparam logic [4:0] OPC_READ  = 5'd1;
   localparam logic [4:0] OPC_WRITE = 5'd2;
   localparam logic [5:0] OPT_XFER  = 6'd2;
   localparam logic [1:0] LEN_FOUR  = 2'b01;

endpackage

// File: rtl/geo_divider.sv
module geo_divider #(
   parameter int NUM_W = 22,
   parameter int DEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             busy,
   output logic [NUM_W-1:0] quot,
   output logic [DEN_W-1:0] rem
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   generate
      if (NUM_W < 2 || DEN_W < 1) begin : g_bad_width
         $error("geo_divider: NUM_W must be >= 2 and DEN_W >= 1");
      end
   endgenerate

   logic [CNT_W-1:0] steps;
   logic [DEN_W-1:0] den_q;
   logic [DEN_W:0]   trial;
   logic [DEN_W:0]   diff;
   logic             take;

   // one restoring step per cycle, quotient bits shift in from the right
   always_comb begin
      trial = {rem, quot[NUM_W-1]};
      diff  = trial - {1'b0, den_q};
      take  = (trial >= {1'b0, den_q});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         steps <= '0;
         quot  <= '0;
         rem   <= '0;
         den_q <= '0;
      end else if (go) begin
         quot  <= num;
         rem   <= '0;
         den_q <= den;
         steps <= CNT_W'(NUM_W);
      end else if (steps != '0) begin
         quot  <= {quot[NUM_W-2:0], take};
         rem   <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
         steps <= steps - 1'b1;
      end
   end

   assign busy = (steps != '0);

endmodule

// File: rtl/cmd_packer.sv
module cmd_packer
   import disk_cmd_pkg::*;
(
   input  logic [1:0]  word_idx,
   input  logic        is_write,
   input  logic [2:0]  dev,
   input  logic [15:0] blocks,
   input  logic [9:0]  cyl,
   input  logic [5:0]  head,
   input  logic [4:0]  sector,
   output logic [15:0] word
);
   always_comb begin
      unique case (word_idx)
         2'd0:    word = {LEN_FOUR, OPT_XFER, dev, is_write ? OPC_WRITE : OPC_READ};
         2'd1:    word = blocks;
         2'd2:    word = {cyl[4:0], head, sector};
         default: word = {11'd0, cyl[9:5]};
      endcase
   end
endmodule

// File: rtl/disk_cmd_issuer.sv
module disk_cmd_issuer
   import disk_cmd_pkg::*;
#(
   parameter int LBA_W       = 22,
   parameter int BC_W        = 25,
   parameter int BLK_SHIFT   = 9,
   parameter int POLL_MAX    = 10000,
   parameter int CMP_TIMEOUT = 1000000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_write,
   input  logic [2:0]       dev_sel,
   input  logic [LBA_W-1:0] lba,
   input  logic [BC_W-1:0]  byte_count,
   input  logic [5:0]       cfg_spt,
   input  logic [6:0]       cfg_heads,
   output logic             attn_req,
   input  logic             attn_done,
   input  logic             attn_ok,
   output logic             cmd_wr,
   output logic [15:0]      cmd_word,
   input  logic             cmd_full,
   input  logic             cmp_valid,
   input  logic             cmp_done,
   output logic             busy,
   output logic             result_valid,
   output logic [2:0]       result_code
);
   localparam int BLK_W  = BC_W - BLK_SHIFT;
   localparam int POLL_W = $clog2(POLL_MAX + 1);
   localparam int WAIT_W = $clog2(CMP_TIMEOUT + 1);
   localparam int DEN_W  = 7;

   generate
      if (LBA_W < 11 || LBA_W > 31) begin : g_bad_lba
         $error("disk_cmd_issuer: LBA_W must lie in 11..31");
      end
      if (BLK_SHIFT < 1 || BLK_W < 1) begin : g_bad_count
         $error("disk_cmd_issuer: BC_W must exceed BLK_SHIFT >= 1");
      end
      if (POLL_MAX < 1 || CMP_TIMEOUT < 1) begin : g_bad_limits
         $error("disk_cmd_issuer: limits must be at least 1");
      end
   endgenerate

   // block count: width of the shifted byte count picks the variant
   logic [15:0] blocks_in;
   generate
      if (BLK_W >= 16) begin : g_blk_trunc
         assign blocks_in = byte_count[BLK_SHIFT +: 16];
         if (BLK_W > 16) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^byte_count[BC_W-1:BLK_SHIFT+16];
         end
      end else begin : g_blk_ext
         assign blocks_in = {{(16-BLK_W){1'b0}}, byte_count[BC_W-1:BLK_SHIFT]};
      end
   endgenerate

   st_e              st;
   res_e             res_q;
   logic             is_wr_q;
   logic [2:0]       dev_q;
   logic [LBA_W-1:0] lba_q;
   logic [LBA_W-1:0] track_q;
   logic [15:0]      blocks_q;
   logic [5:0]       spt_q;
   logic [6:0]       heads_q;
   logic [4:0]       sec_q;
   logic [5:0]       head_q;
   logic [9:0]       cyl_q;
   logic [1:0]       word_idx;
   logic [POLL_W-1:0] poll_cnt;
   logic [WAIT_W-1:0] wait_cnt;

   logic             div_go;
   logic [LBA_W-1:0] div_num;
   logic [DEN_W-1:0] div_den;
   logic             div_busy;
   logic [LBA_W-1:0] div_quot;
   logic [DEN_W-1:0] div_rem;

   always_comb begin
      div_go  = (st == ST_GO_TRK) || (st == ST_GO_CYL);
      div_num = (st == ST_GO_TRK) ? lba_q : track_q;
      div_den = (st == ST_GO_TRK) ? {1'b0, spt_q} : heads_q;
   end

   geo_divider #(.NUM_W(LBA_W), .DEN_W(DEN_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (div_go),
      .num  (div_num),
      .den  (div_den),
      .busy (div_busy),
      .quot (div_quot),
      .rem  (div_rem)
   );

   logic unused_bits;
   assign unused_bits = ^{div_rem[DEN_W-1], byte_count[BLK_SHIFT-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         res_q    <= RES_OK;
         is_wr_q  <= 1'b0;
         dev_q    <= '0;
         lba_q    <= '0;
         track_q  <= '0;
         blocks_q <= '0;
         spt_q    <= '0;
         heads_q  <= '0;
         sec_q    <= '0;
         head_q   <= '0;
         cyl_q    <= '0;
         word_idx <= '0;
         poll_cnt <= '0;
         wait_cnt <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               is_wr_q  <= is_write;
               dev_q    <= dev_sel;
               lba_q    <= lba;
               blocks_q <= blocks_in;
               spt_q    <= cfg_spt;
               heads_q  <= cfg_heads;
               st       <= ST_GO_TRK;
            end
            ST_GO_TRK: st <= ST_RUN_TRK;
            ST_RUN_TRK: if (!div_busy) begin
               track_q <= div_quot;
               sec_q   <= div_rem[4:0];
               st      <= ST_GO_CYL;
            end
            ST_GO_CYL: st <= ST_RUN_CYL;
            ST_RUN_CYL: if (!div_busy) begin
               cyl_q  <= div_quot[9:0];
               head_q <= div_rem[5:0];
               st     <= ST_ATTN;
            end
            ST_ATTN: if (attn_done) begin
               word_idx <= '0;
               if (attn_ok) begin
                  st <= ST_SEND;
               end else begin
                  res_q <= RES_ATTN_FAIL;
                  st    <= ST_DONE;
               end
            end
            ST_SEND: begin
               poll_cnt <= '0;
               st       <= ST_POLL;
            end
            ST_POLL: begin
               if (!cmd_full) begin
                  if (word_idx == 2'd3) begin
                     wait_cnt <= '0;
                     st       <= ST_WAIT;
                  end else begin
                     word_idx <= word_idx + 1'b1;
                     st       <= ST_SEND;
                  end
               end else if (poll_cnt == POLL_W'(POLL_MAX - 1)) begin
                  res_q <= RES_SLOW;
                  st    <= ST_DONE;
               end else begin
                  poll_cnt <= poll_cnt + 1'b1;
               end
            end
            ST_WAIT: begin
               if (cmp_valid) begin
                  res_q <= cmp_done ? RES_OK : RES_IO_ERR;
                  st    <= ST_DONE;
               end else if (wait_cnt == WAIT_W'(CMP_TIMEOUT - 1)) begin
                  res_q <= RES_TIMEOUT;
                  st    <= ST_DONE;
               end else begin
                  wait_cnt <= wait_cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   cmd_packer u_pack (
      .word_idx(word_idx),
      .is_write(is_wr_q),
      .dev     (dev_q),
      .blocks  (blocks_q),
      .cyl     (cyl_q),
      .head    (head_q),
      .sector  (sec_q),
      .word    (cmd_word)
   );

   assign busy         = (st != ST_IDLE);
   assign attn_req     = (st == ST_ATTN);
   assign cmd_wr       = (st == ST_SEND);
   assign result_valid = (st == ST_DONE);
   assign result_code  = res_q;

endmodule

// File: rtl/disk_cmd_checker.sv
module disk_cmd_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        attn_req,
   input logic        attn_done,
   input logic        attn_ok,
   input logic        cmd_wr,
   input logic [15:0] cmd_word,
   input logic        cmd_full,
   input logic        cmp_valid,
   input logic        cmp_done,
   input logic        result_valid,
   input logic [2:0]  result_code
);
   logic       granted;
   logic [2:0] wcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         granted <= 1'b0;
         wcnt    <= '0;
      end else if (result_valid) begin
         granted <= 1'b0;
         wcnt    <= '0;
      end else begin
         if (attn_req && attn_done && attn_ok) granted <= 1'b1;
         if (cmd_wr) wcnt <= wcnt + 1'b1;
      end
   end

   assert_attn_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      attn_req && !attn_done |=> attn_req);

   assert_grant_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> granted);

   assert_no_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> !cmd_full);

   assert_word_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> !cmd_wr);

   assert_max_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> wcnt < 3'd4);

   assert_head_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && wcnt == 3'd0 |-> cmd_word[15:8] == 8'h42);

   assert_last_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && wcnt == 3'd3 |-> cmd_word[15:5] == 11'd0);

   assert_ok_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid && result_code == 3'd0 |-> $past(cmp_valid && cmp_done));

   assert_result_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

endmodule

bind disk_cmd_issuer disk_cmd_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .attn_req    (attn_req),
   .attn_done   (attn_done),
   .attn_ok     (attn_ok),
   .cmd_wr      (cmd_wr),
   .cmd_word    (cmd_word),
   .cmd_full    (cmd_full),
   .cmp_valid   (cmp_valid),
   .cmp_done    (cmp_done),
   .result_valid(result_valid),
   .result_code (result_code)
);

// File: tb/disk_cmd_issuer_bench.sv
module disk_cmd_issuer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LBA_W      = 22;
   localparam int BC_W       = 25;
   localparam int BLK_SHIFT  = 9;
   localparam int POLL_MAX   = 16;
   localparam int CMP_TO     = 40;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             is_write = 1'b0;
   logic [2:0]       dev_sel = '0;
   logic [LBA_W-1:0] lba = '0;
   logic [BC_W-1:0]  byte_count = '0;
   logic [5:0]       cfg_spt = 6'd1;
   logic [6:0]       cfg_heads = 7'd1;
   logic             attn_req, attn_done, attn_ok;
   logic             cmd_wr, cmd_full;
   logic [15:0]      cmd_word;
   logic             cmp_valid, cmp_done;
   logic             busy, result_valid;
   logic [2:0]       result_code;

   int  tests = 0;
   int  fails = 0;
   int  full_hold = 0;
   int  cmp_at = 0;
   int  attn_delay = 0;
   bit  attn_ok_cfg = 1'b1;
   bit  cmp_ok_cfg = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   disk_cmd_issuer #(
      .LBA_W(LBA_W), .BC_W(BC_W), .BLK_SHIFT(BLK_SHIFT),
      .POLL_MAX(POLL_MAX), .CMP_TIMEOUT(CMP_TO)
   ) u_disk_cmd_issuer (
      .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
      .dev_sel(dev_sel), .lba(lba), .byte_count(byte_count),
      .cfg_spt(cfg_spt), .cfg_heads(cfg_heads),
      .attn_req(attn_req), .attn_done(attn_done), .attn_ok(attn_ok),
      .cmd_wr(cmd_wr), .cmd_word(cmd_word), .cmd_full(cmd_full),
      .cmp_valid(cmp_valid), .cmp_done(cmp_done),
      .busy(busy), .result_valid(result_valid), .result_code(result_code)
   );

   // attachment, attention and completion models
   int acnt = 0;
   int hold = 0;
   int wrcount = 0;
   int ccnt = 0;
   logic full_r = 1'b0;

   always @(posedge clk) begin
      if (start) begin
         acnt    <= 0;
         wrcount <= 0;
         ccnt    <= 0;
      end else begin
         if (attn_req) acnt <= acnt + 1;
         if (cmd_wr) begin
            full_r  <= (full_hold != 0);
            hold    <= full_hold;
            wrcount <= wrcount + 1;
            ccnt    <= (full_hold == 0 && wrcount == 3) ? 1 : 0;
         end else if (full_r) begin
            if (hold <= 1) begin
               full_r <= 1'b0;
               if (wrcount == 4) ccnt <= 1;
            end
            hold <= hold - 1;
         end else if (ccnt != 0 && ccnt < 100000) begin
            ccnt <= ccnt + 1;
         end
      end
   end

   assign cmd_full  = full_r;
   assign attn_done = attn_req && (acnt == attn_delay);
   assign attn_ok   = attn_ok_cfg;
   assign cmp_valid = (ccnt != 0) && (ccnt == cmp_at + 2);
   assign cmp_done  = cmp_ok_cfg;

   function automatic logic [15:0] exp_word(int idx, int a, int spt, int hd,
                                            int bytes, bit wr, int dev);
      int trk, sec, h, cyl;
      trk = a / spt;
      sec = a % spt;
      h   = trk % hd;
      cyl = (trk / hd) & 10'h3FF;
      case (idx)
         0: exp_word = {2'b01, 6'd2, 3'(dev), wr ? 5'd2 : 5'd1};
         1: exp_word = 16'(bytes >> BLK_SHIFT);
         2: exp_word = {5'(cyl), 6'(h), 5'(sec)};
         default: exp_word = {11'd0, 5'(cyl >> 5)};
      endcase
   endfunction

   task automatic check(bit ok, string req, string what, int act, int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic run_cmd(int a, int spt, int hd, int bytes, bit wr, int dev,
                          int fh, int ca, bit cok, bit aok, int ad, bit inject);
      logic [15:0] words[8];
      int   nw = 0;
      bit   got = 1'b0;
      int   code = 0;
      int   ecode, ew;
      string rtag;
      full_hold = fh; cmp_at = ca; cmp_ok_cfg = cok;
      attn_ok_cfg = aok; attn_delay = ad;
      @(negedge clk);
      lba = LBA_W'(a); cfg_spt = 6'(spt); cfg_heads = 7'(hd);
      byte_count = BC_W'(bytes); is_write = wr; dev_sel = 3'(dev);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 0; cyc < 3000; cyc++) begin
         if (inject && cyc == 2) begin
            lba = LBA_W'(a) ^ LBA_W'(22'h155); is_write = ~wr; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         if (cmd_wr) begin
            if (nw < 8) words[nw] = cmd_word;
            nw++;
         end
         if (result_valid) begin
            got = 1'b1;
            code = int'(result_code);
            break;
         end
         @(negedge clk);
      end
      start = 1'b0;
      if (!aok)               begin ecode = 4; ew = 0; rtag = "R6";  end
      else if (fh >= POLL_MAX) begin ecode = 2; ew = 1; rtag = "R8";  end
      else if (ca >= CMP_TO)  begin ecode = 3; ew = 4; rtag = "R10"; end
      else                    begin ecode = cok ? 0 : 1; ew = 4; rtag = "R9"; end
      check(got, "R11", "result pulse seen", int'(got), 1);
      check(code == ecode, rtag, "result code", code, ecode);
      check(nw == ew, "R7", "words written", nw, ew);
      for (int i = 0; i < ew && i < 4; i++) begin
         logic [15:0] e;
         e = exp_word(i, a, spt, hd, bytes, wr, dev);
         check(words[i] == e,
               i == 0 ? (inject ? "R12" : "R3") : (i == 1 ? "R4" : "R2/R5"),
               $sformatf("word %0d", i), int'(words[i]), int'(e));
      end
      @(negedge clk);
      check(!busy && !result_valid, "R11", "idle after result",
            int'({busy, result_valid}), 0);
      if (inject) begin
         repeat (80) @(negedge clk);
         check(!busy && !cmd_wr, "R12", "no second command", int'(busy), 0);
      end
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      check(!busy && !attn_req && !cmd_wr && !result_valid && result_code == 3'd0,
            "R1", "outputs in reset",
            int'({busy, attn_req, cmd_wr, result_valid, result_code}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !attn_req && !cmd_wr && !result_valid, "R1",
            "outputs after reset", int'({busy, attn_req, cmd_wr, result_valid}), 0);

      // directed corner cases
      run_cmd(0, 17, 4, 512, 1'b0, 0, 0, 0, 1'b1, 1'b1, 0, 1'b0);
      run_cmd(22'h3FFFFF, 32, 64, 16'hFFFF * 512 + 511, 1'b1, 7, 1, 3, 1'b1, 1'b1, 2, 1'b0);
      run_cmd(12345, 1, 1, 1024, 1'b1, 1, 2, 1, 1'b1, 1'b1, 0, 1'b0);
      run_cmd(777, 13, 5, 4096, 1'b0, 2, POLL_MAX - 1, 2, 1'b1, 1'b1, 1, 1'b0);
      run_cmd(777, 13, 5, 4096, 1'b0, 2, POLL_MAX, 2, 1'b1, 1'b1, 1, 1'b0);
      run_cmd(4242, 31, 9, 2048, 1'b1, 3, 1, CMP_TO - 1, 1'b1, 1'b1, 0, 1'b0);
      run_cmd(4242, 31, 9, 2048, 1'b1, 3, 1, CMP_TO, 1'b1, 1'b1, 0, 1'b0);
      run_cmd(99, 8, 2, 512, 1'b0, 1, 0, 5, 1'b0, 1'b1, 0, 1'b0);
      run_cmd(99, 8, 2, 512, 1'b0, 1, 0, 5, 1'b1, 1'b0, 3, 1'b0);
      run_cmd(54321, 20, 7, 3000, 1'b0, 5, 1, 2, 1'b1, 1'b1, 1, 1'b1);

      // constrained random commands
      for (int n = 0; n < 40; n++) begin
         int a, spt, hd, bytes, fh, ca, ad;
         bit wr, cok, aok;
         a     = int'($urandom_range(0, 22'h3FFFFF));
         spt   = int'($urandom_range(1, 32));
         hd    = int'($urandom_range(1, 64));
         bytes = int'($urandom_range(1, 400)) * 512 + int'($urandom_range(0, 511));
         wr    = 1'($urandom_range(0, 1));
         fh    = int'($urandom_range(0, 5));
         ca    = int'($urandom_range(0, 12));
         ad    = int'($urandom_range(0, 4));
         cok   = ($urandom_range(0, 7) != 0);
         aok   = ($urandom_range(0, 9) != 0);
         run_cmd(a, spt, hd, bytes, wr, int'($urandom_range(0, 7)),
                 fh, ca, cok, aok, ad, 1'b0);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule